// File: doc/BRIEF.md
# Delay-Code Offset Servo

This block closes the digital loop that cancels electrode DC offset in a front end built from delay lines. Once per sample it receives the measured delay of the positive delay chain as a binary time code. It compares that code against four programmable thresholds. An outer pair of thresholds starts a correction and an inner pair ends it, so the comparison has hysteresis. The outcome is a pair of mutually exclusive step requests. These requests walk a saturating level counter, and the counter is decoded into a 32-line thermometer switch word. The switch word sets how many unit current sources the downstream current converter enables. Each step corresponds to roughly 3 mV of offset correction at the input.

The four thresholds are captured while reset is held, and their ordering is checked at that point. If the ordering is wrong, the loop stays frozen until the next reset. After reset the loop needs some time to converge. A settled flag tells the consumer when samples can be trusted: it rises after a run of sample cycles that produce no request.

Top module: `offs_servo`

## Requirements
- R1: While reset is high on a clock edge, the level becomes 16, `sw_word` becomes 32'h0000FFFF, and `req_up`, `req_dn` and `settled` become 0.
- R2: On a sample edge (`smp_vld`=1), a code strictly above `thr_max` sets `req_dn`. A code strictly below `thr_mid_hi` clears it. Any other code leaves it unchanged.
- R3: On a sample edge, a code strictly below `thr_min` sets `req_up`. A code strictly above `thr_mid_lo` clears it. Any other code leaves it unchanged.
- R4: `req_up` and `req_dn` are never high in the same cycle.
- R5: On the same sample edge that updates the requests, the level rises by one if the new `req_up` is 1 and falls by one if the new `req_dn` is 1. It saturates at 0 and 31 rather than wrapping.
- R6: On an edge with `smp_vld`=0, requests, level, switch word and settled flag all keep their values, whatever `dly_code` carries.
- R7: `sw_word` is thermometer coded from the level: a level of k drives bits 0 to k-1 high and all other bits low. It is registered and changes on the same edge as `level`.
- R8: `settled` rises on the 8th consecutive sample edge that leaves both requests at 0. It falls on the first sample edge that leaves either request at 1.
- R9: The thresholds are captured while reset is high. `cfg_err` is set unless thr_min < thr_mid_lo < thr_mid_hi < thr_max (strict). While `cfg_err` is 1, samples are ignored: requests stay 0, the level holds and `settled` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also captures the thresholds |
| smp_vld | input | 1 | Marks a clock edge that carries a new delay sample |
| dly_code | input | 10 | Measured positive-chain delay as a time code |
| thr_min | input | 10 | Outer low threshold (starts an upward correction) |
| thr_mid_lo | input | 10 | Inner low threshold (ends an upward correction) |
| thr_mid_hi | input | 10 | Inner high threshold (ends a downward correction) |
| thr_max | input | 10 | Outer high threshold (starts a downward correction) |
| req_up | output | 1 | Latched upward step request |
| req_dn | output | 1 | Latched downward step request |
| level | output | 5 | Current correction level |
| sw_word | output | 32 | Thermometer switch word for the current converter |
| settled | output | 1 | Loop has been quiet for 8 samples |
| cfg_err | output | 1 | Captured thresholds are not strictly ordered |

## Verification
The bench targets codes that sit exactly on each threshold. A design that used inclusive comparisons would set or clear a request one code too early, and the hysteresis band would shrink. It drives the level into both rails for many samples, where a wrapping counter would jump between 0 and 31 and flip the whole switch word. Idle cycles carrying out-of-band codes expose a design that ignores `smp_vld`. A plant whose code follows the level checks that convergence raises `settled` on exactly the eighth quiet sample. A misordered threshold set must freeze the loop, where a design without the check would step on garbage windows.

// File: rtl/offs_pkg.sv
package offs_pkg;

  typedef enum logic [1:0] {
    MV_HOLD = 2'b00,
    MV_UP   = 2'b01,
    MV_DN   = 2'b10
  } move_e;

  localparam int DEF_CODE_W   = 10;
  localparam int DEF_CNT_W    = 5;
  localparam int DEF_SETTLE_N = 8;

endpackage

// File: rtl/offs_cfg_chk.sv
module offs_cfg_chk #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] thr_min,
  input  logic [CODE_W-1:0] thr_mid_lo,
  input  logic [CODE_W-1:0] thr_mid_hi,
  input  logic [CODE_W-1:0] thr_max,
  output logic [CODE_W-1:0] q_min,
  output logic [CODE_W-1:0] q_mid_lo,
  output logic [CODE_W-1:0] q_mid_hi,
  output logic [CODE_W-1:0] q_max,
  output logic              cfg_err
);

  localparam int N_THR = 4;

  logic [CODE_W-1:0] thr_vec [N_THR];
  logic [N_THR-2:0]  ordered;

  assign thr_vec[0] = thr_min;
  assign thr_vec[1] = thr_mid_lo;
  assign thr_vec[2] = thr_mid_hi;
  assign thr_vec[3] = thr_max;

  // each neighbouring pair must rise strictly
  genvar g;
  generate
    for (g = 0; g < N_THR - 1; g++) begin : g_pair
      assign ordered[g] = thr_vec[g] < thr_vec[g+1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_min    <= thr_min;
      q_mid_lo <= thr_mid_lo;
      q_mid_hi <= thr_mid_hi;
      q_max    <= thr_max;
      cfg_err  <= ~(&ordered);
    end
  end

endmodule

// File: rtl/offs_hyst_flag.sv
module offs_hyst_flag #(
  parameter int CODE_W    = 10,
  parameter bit SET_ABOVE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] set_thr,
  input  logic [CODE_W-1:0] clr_thr,
  output logic              flag_nxt,
  output logic              flag_q
);

  logic hit_set;
  logic hit_clr;

  generate
    if (SET_ABOVE) begin : g_above
      assign hit_set = code > set_thr;
      assign hit_clr = code < clr_thr;
    end else begin : g_below
      assign hit_set = code < set_thr;
      assign hit_clr = code > clr_thr;
    end
  endgenerate

  always_comb begin
    flag_nxt = flag_q;
    if (en) begin
      if (hit_set)      flag_nxt = 1'b1;
      else if (hit_clr) flag_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= 1'b0;
    else     flag_q <= flag_nxt;
  end

endmodule

// File: rtl/offs_step_cnt.sv
module offs_step_cnt
  import offs_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  move_e                 move,
  output logic [CNT_W-1:0]      level,
  output logic [(1<<CNT_W)-1:0] sw_word
);

  localparam int              N_SW    = 1 << CNT_W;
  localparam logic [CNT_W-1:0] LVL_TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LVL_MID = CNT_W'(N_SW / 2);

  logic [CNT_W-1:0] lvl_nxt;
  logic [N_SW-1:0]  sw_nxt;

  always_comb begin
    lvl_nxt = level;
    if (en) begin
      unique case (move)
        MV_UP:   if (level != LVL_TOP) lvl_nxt = level + 1'b1;
        MV_DN:   if (level != '0)      lvl_nxt = level - 1'b1;
        default: lvl_nxt = level;
      endcase
    end
  end

  genvar i;
  generate
    for (i = 0; i < N_SW; i++) begin : g_therm
      assign sw_nxt[i] = {1'b0, lvl_nxt} > (CNT_W+1)'(i);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      level   <= LVL_MID;
      sw_word <= {{(N_SW/2){1'b0}}, {(N_SW/2){1'b1}}};
    end else begin
      level   <= lvl_nxt;
      sw_word <= sw_nxt;
    end
  end

endmodule

// File: rtl/offs_settle.sv
module offs_settle #(
  parameter int SETTLE_N = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic busy,
  output logic settled
);

  localparam int              QW    = $clog2(SETTLE_N + 1);
  localparam logic [QW-1:0]   Q_TOP = QW'(SETTLE_N);

  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q <= '0;
      settled <= 1'b0;
    end else if (en) begin
      if (busy) begin
        quiet_q <= '0;
        settled <= 1'b0;
      end else if (quiet_q != Q_TOP) begin
        quiet_q <= quiet_q + 1'b1;
        settled <= (quiet_q + 1'b1) == Q_TOP;
      end
    end
  end

endmodule

// File: rtl/offs_servo.sv
module offs_servo
  import offs_pkg::*;
#(
  parameter int CODE_W   = DEF_CODE_W,
  parameter int CNT_W    = DEF_CNT_W,
  parameter int SETTLE_N = DEF_SETTLE_N
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  smp_vld,
  input  logic [CODE_W-1:0]     dly_code,
  input  logic [CODE_W-1:0]     thr_min,
  input  logic [CODE_W-1:0]     thr_mid_lo,
  input  logic [CODE_W-1:0]     thr_mid_hi,
  input  logic [CODE_W-1:0]     thr_max,
  output logic                  req_up,
  output logic                  req_dn,
  output logic [CNT_W-1:0]      level,
  output logic [(1<<CNT_W)-1:0] sw_word,
  output logic                  settled,
  output logic                  cfg_err
);

  logic [CODE_W-1:0] q_min, q_mid_lo, q_mid_hi, q_max;
  logic              loop_en;
  logic              up_nxt, dn_nxt;
  move_e             move;

  offs_cfg_chk #(.CODE_W(CODE_W)) u_cfg (
    .clk(clk), .rst(rst),
    .thr_min(thr_min), .thr_mid_lo(thr_mid_lo),
    .thr_mid_hi(thr_mid_hi), .thr_max(thr_max),
    .q_min(q_min), .q_mid_lo(q_mid_lo),
    .q_mid_hi(q_mid_hi), .q_max(q_max),
    .cfg_err(cfg_err)
  );

  assign loop_en = smp_vld & ~cfg_err;

  // outer high threshold raises the down request, inner high drops it
  offs_hyst_flag #(.CODE_W(CODE_W), .SET_ABOVE(1'b1)) u_dn (
    .clk(clk), .rst(rst), .en(loop_en), .code(dly_code),
    .set_thr(q_max), .clr_thr(q_mid_hi),
    .flag_nxt(dn_nxt), .flag_q(req_dn)
  );

  // outer low threshold raises the up request, inner low drops it
  offs_hyst_flag #(.CODE_W(CODE_W), .SET_ABOVE(1'b0)) u_up (
    .clk(clk), .rst(rst), .en(loop_en), .code(dly_code),
    .set_thr(q_min), .clr_thr(q_mid_lo),
    .flag_nxt(up_nxt), .flag_q(req_up)
  );

  always_comb begin
    if (up_nxt)      move = MV_UP;
    else if (dn_nxt) move = MV_DN;
    else             move = MV_HOLD;
  end

  offs_step_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(loop_en), .move(move),
    .level(level), .sw_word(sw_word)
  );

  offs_settle #(.SETTLE_N(SETTLE_N)) u_settle (
    .clk(clk), .rst(rst), .en(loop_en),
    .busy(up_nxt | dn_nxt), .settled(settled)
  );

endmodule

// File: rtl/offs_servo_chk.sv
module offs_servo_chk #(
  parameter int CNT_W = 5
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  smp_vld,
  input logic                  req_up,
  input logic                  req_dn,
  input logic [CNT_W-1:0]      level,
  input logic [(1<<CNT_W)-1:0] sw_word,
  input logic                  settled,
  input logic                  cfg_err
);

  localparam int N_SW = 1 << CNT_W;

  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= ~rst;

  // R4: requests are exclusive
  p_excl_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    !(req_up && req_dn));

  // R5: level moves by at most one step and never wraps
  p_step_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    1'b1 |=> ((level == $past(level)) ||
              ({1'b0, level} == {1'b0, $past(level)} + 1'b1) ||
              ({1'b0, level} + 1'b1 == {1'b0, $past(level)})));

  // R6: an edge without a sample leaves the loop state alone
  p_idle_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    !smp_vld |=> ($stable(level) && $stable(req_up) && $stable(req_dn)
                  && $stable(settled)));

  // R7: switch word is a contiguous run from bit 0 sized by the level
  p_therm_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    ($countones(sw_word) == int'(level)) &&
    ((sw_word & (sw_word + 1'b1)) == '0));

  // R8: a pending request rules out the settled flag
  p_settle_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    (req_up || req_dn) |-> !settled);

  // R9: a bad threshold set keeps the loop silent
  p_freeze_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    cfg_err |-> (!req_up && !req_dn && !settled));

  initial begin
    assert (N_SW >= 2) else $error("switch bus too narrow");
  end

endmodule

bind offs_servo offs_servo_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .smp_vld(smp_vld),
  .req_up(req_up), .req_dn(req_dn), .level(level),
  .sw_word(sw_word), .settled(settled), .cfg_err(cfg_err)
);

// File: tb/offs_servo_bench.sv
module offs_servo_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 10;
  localparam int CNT_W      = 5;
  localparam int SETTLE_N   = 8;
  localparam int LVL_TOP    = (1 << CNT_W) - 1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              smp_vld = 1'b0;
  logic [CODE_W-1:0] dly_code = '0;
  logic [CODE_W-1:0] thr_min = 10'd100, thr_mid_lo = 10'd180;
  logic [CODE_W-1:0] thr_mid_hi = 10'd220, thr_max = 10'd300;
  logic              req_up, req_dn, settled, cfg_err;
  logic [CNT_W-1:0]  level;
  logic [31:0]       sw_word;

  offs_servo u_offs_servo (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .dly_code(dly_code),
    .thr_min(thr_min), .thr_mid_lo(thr_mid_lo),
    .thr_mid_hi(thr_mid_hi), .thr_max(thr_max),
    .req_up(req_up), .req_dn(req_dn), .level(level),
    .sw_word(sw_word), .settled(settled), .cfg_err(cfg_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, n_cyc = 0;
  bit done = 1'b0;

  // reference model state
  int m_min, m_ml, m_mh, m_max;
  int m_up, m_dn, m_lvl, m_quiet, m_set, m_err;

  function automatic void chk(string tag, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, n_cyc);
    end
  endfunction

  function automatic void model_edge(bit r, bit v, int code);
    if (r) begin
      m_min = int'(thr_min); m_ml = int'(thr_mid_lo);
      m_mh = int'(thr_mid_hi); m_max = int'(thr_max);
      m_err = !(m_min < m_ml && m_ml < m_mh && m_mh < m_max);
      m_up = 0; m_dn = 0; m_lvl = 16; m_quiet = 0; m_set = 0;
    end else if (v && !m_err) begin
      if (code > m_max) m_dn = 1; else if (code < m_mh) m_dn = 0;
      if (code < m_min) m_up = 1; else if (code > m_ml) m_up = 0;
      if (m_up && m_lvl < LVL_TOP) m_lvl++;
      if (m_dn && m_lvl > 0) m_lvl--;
      if (m_up || m_dn) begin m_quiet = 0; m_set = 0; end
      else if (m_quiet < SETTLE_N) begin
        m_quiet++; m_set = (m_quiet == SETTLE_N);
      end
    end
  endfunction

  // one clock: inputs already set before the edge, compare at the falling edge
  task automatic cyc(bit r, bit v, int code, string tag);
    rst = r; smp_vld = v; dly_code = CODE_W'(code);
    @(posedge clk);
    model_edge(r, v, code);
    @(negedge clk);
    n_cyc++;
    chk({tag, " req_dn (R2)"}, req_dn, m_dn);
    chk({tag, " req_up (R3)"}, req_up, m_up);
    chk({tag, " level (R5)"}, level, m_lvl);
    chk({tag, " sw_word (R7)"}, sw_word, (64'd1 << m_lvl) - 1);
    chk({tag, " settled (R8)"}, settled, m_set);
    chk({tag, " cfg_err (R9)"}, cfg_err, m_err);
    chk({tag, " exclusive (R4)"}, req_up & req_dn, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset values
    cyc(1, 0, 0, "R1 reset");
    cyc(1, 1, 900, "R1 reset with sample");
    // R2: exact boundaries first, then drive down to the floor (R5 low rail)
    cyc(0, 1, 300, "R2 code==max no set");
    for (int k = 0; k < 20; k++) cyc(0, 1, 350, "R2/R5 down to floor");
    cyc(0, 1, 250, "R2 hold in band");
    cyc(0, 1, 220, "R2 code==mid_hi still held");
    cyc(0, 1, 219, "R2 clear below mid_hi");
    // R6: idle cycles with extreme codes
    for (int k = 0; k < 4; k++) cyc(0, 0, (k % 2) ? 5 : 1000, "R6 idle ignored");
    // R8: quiet samples until settled
    for (int k = 0; k < 10; k++) cyc(0, 1, 200, "R8 quiet run");
    // R3: boundaries, then drive up to ceiling (R5 high rail)
    cyc(0, 1, 100, "R3 code==min no set");
    for (int k = 0; k < 40; k++) cyc(0, 1, 50, "R3/R5 up to ceiling");
    cyc(0, 1, 150, "R3 hold in band");
    cyc(0, 1, 180, "R3 code==mid_lo still held");
    cyc(0, 1, 181, "R3 clear above mid_lo");
    // R4: straight swap from low to high extreme
    cyc(0, 1, 20, "R4 up");
    cyc(0, 1, 1000, "R4 swap to down");
    cyc(0, 1, 20, "R4 swap to up");
    // R1: reset mid-run
    cyc(1, 0, 0, "R1 mid-run reset");
    // R8: closed loop, code follows level
    for (int k = 0; k < 40; k++) begin
      int c = 200 + 12 * (int'(level) - 5);
      if (c < 0) c = 0;
      if (c > 1023) c = 1023;
      cyc(0, 1, c, "R8 closed loop");
    end
    chk("R8 closed loop settled", settled, 1);
    // R8: a new request drops settled
    cyc(0, 1, 400, "R8 drop on request");
    // R9: misordered thresholds freeze the loop
    thr_min = 10'd200; thr_mid_lo = 10'd180;
    cyc(1, 0, 0, "R9 bad capture");
    for (int k = 0; k < 12; k++) cyc(0, 1, (k % 2) ? 10 : 900, "R9 frozen");
    thr_mid_hi = 10'd180;
    thr_min = 10'd100; thr_mid_lo = 10'd180;
    cyc(1, 0, 0, "R9 equal pair capture");
    cyc(0, 1, 900, "R9 equal pair frozen");
    thr_mid_hi = 10'd220;
    cyc(1, 0, 0, "R9 good capture");
    cyc(0, 1, 900, "R9 recovered");
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

endmodule